// File: doc/BRIEF.md
# Factorial Engine with Table-Driven Control

This block computes N! for a 32-bit input N. Two 32-bit registers form the datapath: an accumulator whose value is the result, and a countdown register. Each register is loaded through a three-way select. The accumulator can hold its value, take the product of the two registers, or take the constant 1. The countdown register can take N, take its own value minus one, or hold its value.

A two-bit control state machine drives both selects. The next state and both select codes are read from an 8-entry, 6-bit constant table. The table is addressed by the current state and a zero flag. The zero flag is taken from the value about to be written into the countdown register, not from the register itself. As a result, the loop ends on the same clock edge that the countdown reaches 0, and the accumulator is never multiplied by zero.

To use the block, hold the synchronous `start_rst` high for one or more cycles with N on `n_in`, then release it. The result appears when `done` rises. Only the low 32 bits of each product are kept.

Top module: `fact_rom_engine`

## Requirements
- R1: While `start_rst` is high at a rising clock edge, the state becomes start (encoding 00), the accumulator and countdown registers clear to 0, and `done` and `result` read 0 after that edge.
- R2: On the first edge after `start_rst` falls, the start state loads the accumulator with 1 (accumulator select code 2) and the countdown with `n_in` (countdown select code 0). The state always moves on to loop (01), and `done` stays low.
- R3: In the loop state, each edge writes accumulator×countdown into the accumulator (select code 1, low 32 bits kept) and countdown−1 into the countdown (select code 1).
- R4: The control table is addressed by {state[1:0], zero_flag}. Each entry holds the accumulator select in data bits [5:4], the countdown select in [3:2] and the next state in [1:0]. The zero flag is 1 when the value about to be written into the countdown is 0.
- R5: For an input N of 1 or more, `done` first rises N+1 edges after `start_rst` falls. At that point `result` equals N! mod 2^32.
- R6: In the done state (10), both registers hold (accumulator select 0, countdown select 2) and the state stays done, so `done` and `result` stay unchanged until the next reset.
- R7: `n_in` is sampled only in the start state. Changing it while in the loop or done state has no effect on `result`.
- R8: The unused state 11 returns to start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| start_rst | input | 1 | Synchronous reset; the run begins on release |
| n_in | input | 32 | Operand N |
| result | output | 32 | Accumulator value, N! once done |
| done | output | 1 | High while in the done state |

## Verification
A wrong table entry or a wrong zero-flag source shows at the ports within one step of the countdown. If the flag comes from the registered countdown, `done` rises one edge late and `result` reads 0. If a loop entry is wrong, the intermediate products drift or `done` never rises. Random values of N from 1 to 40 check both the cycle on which `done` rises and the final value, including wrapped products. Directed runs for N=1 and N=5, a change of `n_in` in mid-run, and a long hold in the done state cover the edges of the table.

// File: rtl/fact_rom_engine.sv
module fact_rom_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         start_rst,
  input  logic [W-1:0] n_in,
  output logic [W-1:0] result,
  output logic         done
);
  localparam logic [1:0] S_START = 2'b00;
  localparam logic [1:0] S_LOOP  = 2'b01;
  localparam logic [1:0] S_DONE  = 2'b10;

  logic [1:0]   state;
  logic [W-1:0] acc, cnt;
  logic [5:0]   ctl_tab [0:7];
  logic [5:0]   probe, word;
  logic [W-1:0] acc_nx, cnt_nx, cnt_try;
  logic         zf;

  // data: [5:4] acc select, [3:2] cnt select, [1:0] next state
  always_comb begin
    ctl_tab[0] = 6'b10_00_01;
    ctl_tab[1] = 6'b10_00_01;
    ctl_tab[2] = 6'b01_01_01;
    ctl_tab[3] = 6'b01_01_10;
    ctl_tab[4] = 6'b00_10_10;
    ctl_tab[5] = 6'b00_10_10;
    ctl_tab[6] = 6'b00_10_00;
    ctl_tab[7] = 6'b00_10_00;
  end

  function automatic logic [W-1:0] cnt_mux(input logic [1:0] sel,
                                           input logic [W-1:0] n,
                                           input logic [W-1:0] c);
    case (sel)
      2'd0:    cnt_mux = n;
      2'd1:    cnt_mux = c - 1'b1;
      default: cnt_mux = c;
    endcase
  endfunction

  // both flag values of an entry share the cnt select, so probe with flag 0
  assign probe   = ctl_tab[{state, 1'b0}];
  assign cnt_try = cnt_mux(probe[3:2], n_in, cnt);
  assign zf      = (cnt_try == '0);
  assign word    = ctl_tab[{state, zf}];
  assign cnt_nx  = cnt_mux(word[3:2], n_in, cnt);

  always_comb begin
    case (word[5:4])
      2'd0:    acc_nx = acc;
      2'd1:    acc_nx = acc * cnt;
      default: acc_nx = {{(W-1){1'b0}}, 1'b1};
    endcase
  end

  always_ff @(posedge clk) begin
    if (start_rst) begin
      state <= S_START;
      acc   <= '0;
      cnt   <= '0;
    end else begin
      state <= word[1:0];
      acc   <= acc_nx;
      cnt   <= cnt_nx;
    end
  end

  assign result = acc;
  assign done   = (state == S_DONE);

  a_r1_reset_start: assert property (@(posedge clk)
    start_rst |=> (state == S_START && acc == '0 && cnt == '0));
  a_r2_start_loads: assert property (@(posedge clk) disable iff (start_rst)
    state == S_START |=> (state == S_LOOP && acc == 1 && cnt == $past(n_in)));
  a_r3_loop_step: assert property (@(posedge clk) disable iff (start_rst)
    state == S_LOOP |=> (cnt == $past(cnt) - 1'b1 && acc == $past(acc) * $past(cnt)));
  a_r4_exit_on_zero: assert property (@(posedge clk) disable iff (start_rst)
    (state == S_LOOP && cnt == 1) |=> state == S_DONE);
  a_r5_no_zero_mult: assert property (@(posedge clk) disable iff (start_rst)
    state == S_LOOP |-> cnt != '0);
  a_r6_done_holds: assert property (@(posedge clk) disable iff (start_rst)
    done |=> (done && $stable(acc) && $stable(cnt)));
  a_r8_legal_state: assert property (@(posedge clk) disable iff (start_rst)
    state != 2'b11);
endmodule

// File: tb/tb_fact_rom_engine.sv
module tb_fact_rom_engine;
  logic        clk = 1'b0;
  logic        start_rst = 1'b1;
  logic [31:0] n_in = 32'd0;
  logic [31:0] result;
  logic        done;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  fact_rom_engine dut (.clk(clk), .start_rst(start_rst), .n_in(n_in),
                       .result(result), .done(done));

  always #5 clk = ~clk;

  function automatic logic [31:0] fact_ref(input int n);
    logic [31:0] p = 32'd1;
    for (int i = 2; i <= n; i++) p = p * i;
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one computation; optionally change n_in after the start edge
  task automatic run(input int n, input bit disturb, input int hold);
    @(negedge clk);
    start_rst = 1'b1;
    n_in = n;
    @(negedge clk);
    chk("R1 result after reset", result, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    start_rst = 1'b0;
    @(negedge clk);
    chk("R2 accumulator after start", result, 32'd1);
    chk("R2 done low after start", {31'd0, done}, 32'd0);
    if (disturb) n_in = n + 7;
    for (int k = 2; k <= n; k++) begin
      @(negedge clk);
      if (done) chk("R5 done early", {31'd0, done}, 32'd0);
      if (k == 2) chk("R3 first product", result, n);
    end
    @(negedge clk);
    chk("R5 done on edge N+1", {31'd0, done}, 32'd1);
    chk(disturb ? "R7 result with n_in changed" : "R5 result", result, fact_ref(n));
    if (disturb) n_in = 32'd3;
    for (int h = 0; h < hold; h++) @(negedge clk);
    if (hold > 0) begin
      chk("R6 done held", {31'd0, done}, 32'd1);
      chk("R6 result held", result, fact_ref(n));
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(1234);
    repeat (2) @(negedge clk);
    run(5, 1'b0, 0);
    run(1, 1'b0, 3);
    run(12, 1'b1, 10);
    run(13, 1'b0, 0);
    run(34, 1'b0, 2);
    for (int t = 0; t < 30; t++) run(1 + ($urandom % 40), t[0], t % 4);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule